// File: doc/BRIEF.md
# Sign-Explicit Add/Subtract/Move ALU Slice

This block is the integer add, subtract and 32-bit move slice of a 64-bit register machine's execute stage. Each cycle it receives an 8-bit operation code, the current destination register value, the source register value and a 32-bit immediate. From these it forms a 64-bit result with no clock and no internal state. The register file writes that result back.

The block follows an explicit-extension policy. Every 32-bit arithmetic operation clears the upper half of the result. The 32-bit register move is the only operation that copies bit 31 into the upper half, so it acts as the sign-extension instruction. Immediate subtraction takes the immediate as the minuend. Because of this, "immediate 0 minus register" gives negation and no separate negate code is needed. Any code outside the supported set raises an illegal flag and forces the result to zero.

The slice is purely combinational, so it has no states and no transitions. The decoder classifies each code into an operation kind (add, subtract, move or none), a width (narrow or wide) and an operand form (register or immediate). Those three fields choose the operand routing and the final result shaping.

Top module: `sxalu_core`

## Requirements
- R1: Codes 0x04 (immediate) and 0x0C (register) return the low 32 bits of dst plus the immediate or src, with bits 63:32 of the result zero.
- R2: Code 0x1C returns the low 32 bits of dst minus src, with bits 63:32 zero.
- R3: Code 0x14 returns the low 32 bits of the immediate minus dst, with bits 63:32 zero; immediate 0 yields the 32-bit negation of dst.
- R4: Codes 0x07 (immediate) and 0x0F (register) return dst plus the operand modulo 2^64, where the 32-bit immediate is sign-extended to 64 bits.
- R5: Code 0x1F returns dst minus src modulo 2^64.
- R6: Code 0x17 returns the sign-extended immediate minus dst modulo 2^64; immediate 0 yields the 64-bit negation of dst.
- R7: Code 0xBC returns src bits 31:0 in bits 31:0 and copies src bit 31 into bits 63:32; dst and the immediate do not affect it.
- R8: Every other code drives illegal high and the result to zero; all nine supported codes drive illegal low.
- R9: Immediate-form codes ignore src, and register-form codes ignore the immediate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 8 | Operation code |
| dst_val | input | DATA_W | Destination register value (left operand) |
| src_val | input | DATA_W | Source register value |
| imm_val | input | IMM_W | Immediate, signed |
| res_val | output | DATA_W | Result to write back |
| bad_op | output | 1 | Unsupported operation code |

## Verification
The bench uses the default parameters, DATA_W = 64 and IMM_W = 32. With these, the narrow half is 32 bits and the immediate has the same width as that half. This width matching is what makes the sign-extension and negation edges reachable. Examples are an immediate of 0x80000000 feeding a 64-bit add, and a move whose source has bit 31 set while its upper bits hold an unrelated pattern. A behavioural reference built on native 64- and 32-bit arithmetic checks every clock against randomly mixed legal and illegal codes. Directed cases cover carries out of bit 31, wraparound at 2^64 and reversed-operand subtraction.

// File: rtl/sxalu_pkg.sv
package sxalu_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OPC_ADD_N_IMM = 8'h04;
    localparam logic [OP_W-1:0] OPC_ADD_N_REG = 8'h0C;
    localparam logic [OP_W-1:0] OPC_SUB_N_IMM = 8'h14;
    localparam logic [OP_W-1:0] OPC_SUB_N_REG = 8'h1C;
    localparam logic [OP_W-1:0] OPC_ADD_W_IMM = 8'h07;
    localparam logic [OP_W-1:0] OPC_ADD_W_REG = 8'h0F;
    localparam logic [OP_W-1:0] OPC_SUB_W_IMM = 8'h17;
    localparam logic [OP_W-1:0] OPC_SUB_W_REG = 8'h1F;
    localparam logic [OP_W-1:0] OPC_MOV_N_REG = 8'hBC;

    typedef enum logic [1:0] {
        KIND_ADD  = 2'd0,
        KIND_SUB  = 2'd1,
        KIND_MOV  = 2'd2,
        KIND_NONE = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     narrow;
        logic     use_imm;
        logic     legal;
    } op_dec_t;

endpackage

// File: rtl/sxalu_decode.sv
module sxalu_decode
    import sxalu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_dec_t         dec
);

    always_comb begin
        dec = '{kind: KIND_NONE, narrow: 1'b0, use_imm: 1'b0, legal: 1'b0};
        unique case (op_code)
            OPC_ADD_N_IMM: dec = '{kind: KIND_ADD, narrow: 1'b1, use_imm: 1'b1, legal: 1'b1};
            OPC_ADD_N_REG: dec = '{kind: KIND_ADD, narrow: 1'b1, use_imm: 1'b0, legal: 1'b1};
            OPC_SUB_N_IMM: dec = '{kind: KIND_SUB, narrow: 1'b1, use_imm: 1'b1, legal: 1'b1};
            OPC_SUB_N_REG: dec = '{kind: KIND_SUB, narrow: 1'b1, use_imm: 1'b0, legal: 1'b1};
            OPC_ADD_W_IMM: dec = '{kind: KIND_ADD, narrow: 1'b0, use_imm: 1'b1, legal: 1'b1};
            OPC_ADD_W_REG: dec = '{kind: KIND_ADD, narrow: 1'b0, use_imm: 1'b0, legal: 1'b1};
            OPC_SUB_W_IMM: dec = '{kind: KIND_SUB, narrow: 1'b0, use_imm: 1'b1, legal: 1'b1};
            OPC_SUB_W_REG: dec = '{kind: KIND_SUB, narrow: 1'b0, use_imm: 1'b0, legal: 1'b1};
            OPC_MOV_N_REG: dec = '{kind: KIND_MOV, narrow: 1'b1, use_imm: 1'b0, legal: 1'b1};
            default:       dec = '{kind: KIND_NONE, narrow: 1'b0, use_imm: 1'b0, legal: 1'b0};
        endcase
    end

endmodule

// File: rtl/sxalu_operands.sv
module sxalu_operands
    import sxalu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  op_dec_t           dec,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              do_sub
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] rhs;

    // Immediate is signed: replicate its top bit across the extra width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_wide = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        end else begin : g_noext
            assign imm_wide = imm_val[DATA_W-1:0];
        end
    endgenerate

    assign rhs = dec.use_imm ? imm_wide : src_val;

    always_comb begin
        opnd_a = dst_val;
        opnd_b = rhs;
        do_sub = 1'b0;
        unique case (dec.kind)
            KIND_ADD: begin
                opnd_a = dst_val;
                opnd_b = rhs;
            end
            KIND_SUB: begin
                do_sub = 1'b1;
                // Immediate forms take the immediate as minuend.
                if (dec.use_imm) begin
                    opnd_a = imm_wide;
                    opnd_b = dst_val;
                end else begin
                    opnd_a = dst_val;
                    opnd_b = src_val;
                end
            end
            KIND_MOV: begin
                opnd_a = src_val;
                opnd_b = '0;
            end
            default: begin
                opnd_a = '0;
                opnd_b = '0;
            end
        endcase
    end

endmodule

// File: rtl/sxalu_addsub.sv
module sxalu_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);

    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};

endmodule

// File: rtl/sxalu_shape.sv
module sxalu_shape
    import sxalu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_dec_t           dec,
    input  logic [DATA_W-1:0] sum,
    input  logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] res_val,
    output logic              bad_op
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] narrow_zx;
    logic [DATA_W-1:0] move_sx;

    assign narrow_zx = {{(DATA_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
    assign move_sx   = {{(DATA_W-HALF_W){opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};

    always_comb begin
        bad_op  = ~dec.legal;
        res_val = '0;
        unique case (dec.kind)
            KIND_ADD, KIND_SUB: res_val = dec.narrow ? narrow_zx : sum;
            KIND_MOV:           res_val = move_sx;
            default:            res_val = '0;
        endcase
    end

endmodule

// File: rtl/sxalu_core.sv
module sxalu_core
    import sxalu_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] res_val,
    output logic              bad_op
);

    op_dec_t           dec;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic              do_sub;
    logic [DATA_W-1:0] sum;

    sxalu_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    sxalu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .dec     (dec),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm_val (imm_val),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .do_sub  (do_sub)
    );

    sxalu_addsub #(.W(DATA_W)) u_add (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (do_sub),
        .sum (sum)
    );

    sxalu_shape #(.DATA_W(DATA_W)) u_shape (
        .dec     (dec),
        .sum     (sum),
        .opnd_a  (opnd_a),
        .res_val (res_val),
        .bad_op  (bad_op)
    );

endmodule

// File: rtl/sxalu_checks.sv
module sxalu_checks #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input logic [7:0]        op_code,
    input logic [DATA_W-1:0] dst_val,
    input logic [DATA_W-1:0] src_val,
    input logic [IMM_W-1:0]  imm_val,
    input logic [DATA_W-1:0] res_val,
    input logic              bad_op
);

    localparam int HALF_W = DATA_W / 2;

    logic known;
    assign known = !$isunknown({op_code, dst_val, src_val, imm_val, res_val, bad_op});

    always_comb begin
        if (known) begin
            if (op_code == 8'h04 || op_code == 8'h0C || op_code == 8'h14 || op_code == 8'h1C)
                assert_narrow_upper_clear_R1: assert (res_val[DATA_W-1:HALF_W] == '0)
                    else $error("narrow result has nonzero upper half");
            if (op_code == 8'hBC)
                assert_move_sign_copy_R7: assert (res_val == {{(DATA_W-HALF_W){src_val[HALF_W-1]}}, src_val[HALF_W-1:0]})
                    else $error("move did not sign-extend");
            if (bad_op)
                assert_illegal_zero_R8: assert (res_val == '0)
                    else $error("illegal code left nonzero result");
            if (op_code == 8'h17 && imm_val == '0)
                assert_wide_negate_R6: assert (res_val + dst_val == '0)
                    else $error("wide negation wrong");
            if (op_code == 8'h1C)
                assert_narrow_sub_inverse_R2: assert (res_val[HALF_W-1:0] + src_val[HALF_W-1:0] == dst_val[HALF_W-1:0])
                    else $error("narrow subtract wrong");
        end
    end

endmodule

bind sxalu_core sxalu_checks #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_checks (
    .op_code (op_code),
    .dst_val (dst_val),
    .src_val (src_val),
    .imm_val (imm_val),
    .res_val (res_val),
    .bad_op  (bad_op)
);

// File: tb/test_sxalu_core.sv
module test_sxalu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  op_code;
    logic [63:0] dst_val;
    logic [63:0] src_val;
    logic [31:0] imm_val;
    logic [63:0] res_val;
    logic        bad_op;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sxalu_core i_sxalu_core (
        .op_code (op_code),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm_val (imm_val),
        .res_val (res_val),
        .bad_op  (bad_op)
    );

    // Behavioural reference from the requirements.
    function automatic void model(input logic [7:0] op, input logic [63:0] d,
                                  input logic [63:0] s, input logic [31:0] i,
                                  output logic [63:0] r, output logic ill);
        longint unsigned iw;
        int unsigned     lo;
        iw  = longint'(signed'(i));
        ill = 1'b0;
        r   = 64'd0;
        case (op)
            8'h04: begin lo = d[31:0] + i;       r = {32'd0, lo}; end
            8'h0C: begin lo = d[31:0] + s[31:0]; r = {32'd0, lo}; end
            8'h1C: begin lo = d[31:0] - s[31:0]; r = {32'd0, lo}; end
            8'h14: begin lo = i - d[31:0];       r = {32'd0, lo}; end
            8'h07: r = d + iw;
            8'h0F: r = d + s;
            8'h1F: r = d - s;
            8'h17: r = iw - d;
            8'hBC: r = longint'(signed'(s[31:0]));
            default: ill = 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] exp_r, input logic exp_b);
        total++;
        if (res_val !== exp_r || bad_op !== exp_b) begin
            bad++;
            $display("FAIL %s op=%h res=%h bad=%b expected res=%h bad=%b",
                     tag, op_code, res_val, bad_op, exp_r, exp_b);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] i);
        @(posedge clk);
        #2;
        op_code = op;
        dst_val = d;
        src_val = s;
        imm_val = i;
        @(negedge clk);
    endtask

    task automatic directed(input string tag, input logic [7:0] op, input logic [63:0] d,
                            input logic [63:0] s, input logic [31:0] i,
                            input logic [63:0] exp_r, input logic exp_b);
        apply(op, d, s, i);
        check(tag, exp_r, exp_b);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] er;
        logic        eb;
        logic [7:0]  ops [12];
        ops = '{8'h04, 8'h0C, 8'h14, 8'h1C, 8'h07, 8'h0F, 8'h17, 8'h1F, 8'hBC,
                8'h24, 8'h84, 8'h00};
        op_code = 8'h00;
        dst_val = '0;
        src_val = '0;
        imm_val = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset idle code", 64'd0, 1'b1);

        // R1: carry out of bit 31 is dropped, upper half cleared
        directed("R1 imm carry", 8'h04, 64'hABCD_0000_FFFF_FFFF, 64'h0, 32'h1, 64'h0, 1'b0);
        directed("R1 reg", 8'h0C, 64'h1111_2222_0000_0010, 64'h9999_0000_0000_0020, 32'h0,
                 64'h0000_0000_0000_0030, 1'b0);
        // R2
        directed("R2 borrow", 8'h1C, 64'h5555_0000_0000_0000, 64'h1, 32'h0,
                 64'h0000_0000_FFFF_FFFF, 1'b0);
        // R3: reversed operands and negation
        directed("R3 negate", 8'h14, 64'h7777_7777_0000_0005, 64'h0, 32'h0,
                 64'h0000_0000_FFFF_FFFB, 1'b0);
        directed("R3 imm minus dst", 8'h14, 64'h3, 64'h0, 32'd10, 64'd7, 1'b0);
        // R4: sign-extended immediate and wraparound
        directed("R4 imm sext", 8'h07, 64'h0, 64'h0, 32'h8000_0000,
                 64'hFFFF_FFFF_8000_0000, 1'b0);
        directed("R4 wrap", 8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'h0, 64'h0, 1'b0);
        // R5
        directed("R5 wide sub", 8'h1F, 64'd3, 64'd5, 32'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
        // R6
        directed("R6 negate", 8'h17, 64'd7, 64'h0, 32'h0, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0);
        directed("R6 neg imm", 8'h17, 64'd1, 64'h0, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
        // R7: dst and imm irrelevant
        directed("R7 negative", 8'hBC, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1234_5678_8000_0000,
                 32'h5A5A_5A5A, 64'hFFFF_FFFF_8000_0000, 1'b0);
        directed("R7 positive", 8'hBC, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF, 32'h0,
                 64'h0000_0000_7FFF_FFFF, 1'b0);
        // R8: removed codes
        directed("R8 mul code", 8'h24, 64'd6, 64'd7, 32'd3, 64'h0, 1'b1);
        directed("R8 neg code", 8'h84, 64'd6, 64'd7, 32'd3, 64'h0, 1'b1);
        // R9: ignored operand
        directed("R9 imm ignores src", 8'h07, 64'd100, 64'hFFFF_0000_FFFF_0000, 32'd5,
                 64'd105, 1'b0);
        directed("R9 reg ignores imm", 8'h0F, 64'd100, 64'd5, 32'hFFFF_FFFF, 64'd105, 1'b0);

        // Mixed random traffic compared with the reference every clock
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  op;
            logic [63:0] d;
            logic [63:0] s;
            logic [31:0] i;
            op = ops[$urandom_range(0, 11)];
            d  = {$urandom, $urandom};
            s  = {$urandom, $urandom};
            i  = $urandom;
            if (n % 7 == 0) i = 32'h0;
            if (n % 11 == 0) s[31] = 1'b1;
            apply(op, d, s, i);
            model(op, d, s, i, er, eb);
            check("R1-9 random (R4 R6 R7 R8)", er, eb);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule